// File: doc/BRIEF.md
# Programmable Clock Output Generator

This block drives one output pin from a choice of sources: the system clock itself, a slow secondary clock given as an enable pulse, or a divided clock made by an 8-bit reload down-counter. The counter runs from a tick at one thirty-second of the system clock, and a toggle stage after it halves the rate. For a reload value n the pin carries a square wave at f32/(2·(n+1)). With a 10 MHz system clock, n = 0x07, 0x26, 0x4D and 0x9B give about 19.5, 4.0, 2.0 and 1.0 kHz. When no clock source is selected, the pin carries an ordinary port data bit.

Software sets the block up through a small register interface. A reload register sets the divide value. A control register carries a run flag in its top bit. A select register picks the source. Everything runs on the system clock. The f32 tick and the secondary clock arrive as single-cycle enable pulses, so the block uses no derived clocks.

Top module: `clkout_gen`

## Requirements
- R1: After reset the run flag is 0, the select field is 00, the live count and the toggle are 0, and the pin carries `port_bit`.
- R2: The select register at address 0xD, bits 1:0, routes the pin: 00 gives `port_bit`, 01 gives the system clock, 10 gives the `fc1_tick` level and 11 gives the divider toggle.
- R3: While the run flag is 0, f32 ticks change neither the count nor the toggle. The toggle holds its last value.
- R4: While running, each f32 tick decrements a nonzero count by one. A tick at count zero loads the reload value and flips the toggle, so one output period is 2·(n+1) ticks.
- R5: Every reload value from 0x00 to 0xFF is valid. With 0x00 the toggle flips on every tick; with 0xFF one period is 512 ticks.
- R6: A write to the reload register (address 0xE) while running leaves the count in progress unchanged and takes effect at the next reload.
- R7: The run flag is bit 7 of the control register at address 0xC. Writes to bits 6..0 are ignored, and those bits read as 0.
- R8: A read of address 0xE returns the live count. A read of 0xD returns the select field in bits 1:0 with zeros above. Unmapped addresses read 0.
- R9: Cycles without an f32 tick leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (also the f1 source) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| f32_tick | input | 1 | Single-cycle enable at system clock / 32 |
| fc1_tick | input | 1 | Single-cycle enable from the secondary clock |
| port_bit | input | 1 | Port data bit used when no clock is selected |
| clk_pin | output | 1 | Output pin |

## Verification
The hardest case to reach is the widest division. With reload 0xFF and a true divide-by-32 tick, one output period takes over sixteen thousand cycles. The stimulus therefore skips a settling period after each reload change and then times a full rise-to-rise interval in ticks. The bench also writes the reload value partway through a count, so the reference model must show that the old count runs out first. It stops the counter in mid-count to prove the toggle holds while ticks keep arriving.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
   typedef enum logic [1:0] {
      SRC_PORT = 2'b00,
      SRC_F1   = 2'b01,
      SRC_FC1  = 2'b10,
      SRC_DIV  = 2'b11
   } src_sel_e;
endpackage

// File: rtl/clkout_regs.sv
module clkout_regs
   import clkout_pkg::*;
#(
   parameter int ADDR_W     = 4,
   parameter int DATA_W     = 8,
   parameter int CNT_W      = 8,
   parameter logic [ADDR_W-1:0] ADDR_CTRL = 4'hC,
   parameter logic [ADDR_W-1:0] ADDR_SEL  = 4'hD,
   parameter logic [ADDR_W-1:0] ADDR_LOAD = 4'hE,
   parameter logic [CNT_W-1:0]  LOAD_RST  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [CNT_W-1:0]  cnt_val,
   output logic              run,
   output logic [CNT_W-1:0]  reload,
   output src_sel_e          sel,
   output logic [DATA_W-1:0] rd_data
);
   localparam int RUN_BIT = DATA_W - 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run    <= 1'b0;
         reload <= LOAD_RST;
         sel    <= SRC_PORT;
      end else if (wr_en) begin
         if (wr_addr == ADDR_CTRL) run <= wr_data[RUN_BIT];
         if (wr_addr == ADDR_LOAD) reload <= wr_data[CNT_W-1:0];
         if (wr_addr == ADDR_SEL)  sel <= src_sel_e'(wr_data[1:0]);
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_CTRL)      rd_data[RUN_BIT] = run;
      else if (rd_addr == ADDR_LOAD) rd_data = DATA_W'(cnt_val);
      else if (rd_addr == ADDR_SEL)  rd_data = DATA_W'(sel);
   end
endmodule

// File: rtl/clkout_divider.sv
module clkout_divider #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] cnt,
   output logic             tog
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   logic at_zero;
   logic step;

   assign at_zero = (cnt == '0);
   assign step    = run & tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         tog <= 1'b0;
      end else if (step) begin
         if (at_zero) begin
            cnt <= reload;
            tog <= ~tog;
         end else begin
            cnt <= cnt - ONE;
         end
      end
   end
endmodule

// File: rtl/clkout_mux.sv
module clkout_mux
   import clkout_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic     f1_clk,
   input  logic     rst_n,
   input  src_sel_e sel,
   input  logic     port_bit,
   input  logic     fc1_lvl,
   input  logic     div_q,
   output logic     pin
);
   logic slow_src;

   always_comb begin
      unique case (sel)
         SRC_PORT: slow_src = port_bit;
         SRC_FC1:  slow_src = fc1_lvl;
         SRC_DIV:  slow_src = div_q;
         default:  slow_src = port_bit;
      endcase
   end

   generate
      if (OUT_REG) begin : g_reg
         logic slow_q;
         always_ff @(posedge f1_clk or negedge rst_n) begin
            if (!rst_n) slow_q <= 1'b0;
            else        slow_q <= slow_src;
         end
         assign pin = (sel == SRC_F1) ? f1_clk : slow_q;
      end else begin : g_comb
         assign pin = !rst_n ? port_bit :
                      (sel == SRC_F1) ? f1_clk : slow_src;
      end
   endgenerate
endmodule

// File: rtl/clkout_gen.sv
module clkout_gen
   import clkout_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 8,
   parameter logic [ADDR_W-1:0] ADDR_CTRL = 4'hC,
   parameter logic [ADDR_W-1:0] ADDR_SEL  = 4'hD,
   parameter logic [ADDR_W-1:0] ADDR_LOAD = 4'hE,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              f32_tick,
   input  logic              fc1_tick,
   input  logic              port_bit,
   output logic              clk_pin
);
   generate
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_width
         $error("clkout_gen: CNT_W must lie in 1..DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("clkout_gen: DATA_W must be at least 2");
      end
      if (ADDR_CTRL == ADDR_SEL || ADDR_CTRL == ADDR_LOAD || ADDR_SEL == ADDR_LOAD) begin : g_bad_map
         $error("clkout_gen: register addresses must differ");
      end
   endgenerate

   logic             run_q;
   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] cnt_q;
   logic             tog_q;
   src_sel_e         sel_q;

   clkout_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
      .ADDR_CTRL(ADDR_CTRL), .ADDR_SEL(ADDR_SEL), .ADDR_LOAD(ADDR_LOAD),
      .LOAD_RST('0)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .cnt_val(cnt_q),
      .run(run_q), .reload(reload_q), .sel(sel_q), .rd_data(rd_data)
   );

   clkout_divider #(.CNT_W(CNT_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(run_q), .tick(f32_tick),
      .reload(reload_q), .cnt(cnt_q), .tog(tog_q)
   );

   clkout_mux #(.OUT_REG(OUT_REG)) u_mux (
      .f1_clk(clk), .rst_n(rst_n), .sel(sel_q), .port_bit(port_bit),
      .fc1_lvl(fc1_tick), .div_q(tog_q), .pin(clk_pin)
   );
endmodule

// File: rtl/clkout_gen_chk.sv
module clkout_gen_chk #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 8,
   parameter logic [ADDR_W-1:0] ADDR_CTRL = 4'hC
) (
   input logic              clk,
   input logic              rst_n,
   input logic              f32_tick,
   input logic              run,
   input logic [CNT_W-1:0]  reload,
   input logic [CNT_W-1:0]  cnt,
   input logic              tog,
   input logic [1:0]        sel,
   input logic              port_bit,
   input logic              clk_pin,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data
);
   assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> ($stable(cnt) && $stable(tog)));

   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !f32_tick |=> $stable(cnt));

   assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && f32_tick && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1) && $stable(tog)));

   assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && f32_tick && cnt == '0) |=> (cnt == $past(reload) && tog != $past(tog)));

   assert_ctrl_low_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == ADDR_CTRL) |-> (rd_data[DATA_W-2:0] == '0));

   assert_port_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == 2'b00) |-> (clk_pin == port_bit));

   assert_div_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == 2'b11) |-> (clk_pin == tog));
endmodule

bind clkout_gen clkout_gen_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_CTRL(ADDR_CTRL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .f32_tick(f32_tick), .run(run_q),
   .reload(reload_q), .cnt(cnt_q), .tog(tog_q), .sel(sel_q),
   .port_bit(port_bit), .clk_pin(clk_pin), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/clkout_gen_bench.sv
`timescale 1ns/1ps
module clkout_gen_bench;
   localparam logic [3:0] A_CTRL = 4'hC;
   localparam logic [3:0] A_SEL  = 4'hD;
   localparam logic [3:0] A_LOAD = 4'hE;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [3:0] rd_addr = A_LOAD;
   logic [7:0] rd_data;
   logic       f32_tick = 1'b0;
   logic       fc1_tick = 1'b0;
   logic       port_bit = 1'b0;
   logic       clk_pin;

   int errors = 0;
   int checks = 0;
   int tick_cnt = 0;
   bit ticks_on = 1'b0;
   bit cmp_on = 1'b0;
   bit done = 1'b0;
   string cur_req = "R1";

   // behavioural reference state
   int r_cnt = 0, r_load = 0, r_sel = 0;
   bit r_run = 0, r_tog = 0;

   always #10 clk = ~clk;

   clkout_gen u_clkout_gen (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .f32_tick(f32_tick), .fc1_tick(fc1_tick), .port_bit(port_bit),
      .clk_pin(clk_pin)
   );

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // stimulus generators on the falling edge
   int pre = 0;
   int fc_div = 0;
   always @(negedge clk) begin
      pre = (pre + 1) % 32;
      f32_tick <= ticks_on && (pre == 0);
      fc_div = (fc_div + 1) % 5;
      fc1_tick <= (fc_div == 0);
   end

   // reference model
   always @(posedge clk) begin
      if (!rst_n) begin
         r_run <= 0; r_sel <= 0; r_cnt <= 0; r_tog <= 0; r_load <= 0;
      end else begin
         if (wr_en && wr_addr == A_CTRL) r_run <= wr_data[7];
         if (wr_en && wr_addr == A_LOAD) r_load <= wr_data;
         if (wr_en && wr_addr == A_SEL)  r_sel <= wr_data[1:0];
         if (r_run && f32_tick) begin
            if (r_cnt == 0) begin r_cnt <= r_load; r_tog <= !r_tog; end
            else r_cnt <= r_cnt - 1;
         end
         if (f32_tick) tick_cnt <= tick_cnt + 1;
      end
   end

   // per-cycle comparison, clk high at the sample point
   always @(posedge clk) begin
      #5;
      if (rst_n && cmp_on) begin
         int exp_pin;
         int exp_rd;
         case (r_sel)
            0: exp_pin = port_bit;
            1: exp_pin = 1;
            2: exp_pin = fc1_tick;
            default: exp_pin = r_tog;
         endcase
         if (rd_addr == A_CTRL)      exp_rd = r_run ? 128 : 0;
         else if (rd_addr == A_LOAD) exp_rd = r_cnt;
         else if (rd_addr == A_SEL)  exp_rd = r_sel;
         else                        exp_rd = 0;
         chk({cur_req, " pin"}, clk_pin, exp_pin);
         chk({cur_req, " rd_data"}, rd_data, exp_rd);
      end
   end

   task automatic wr(logic [3:0] a, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_rise();
      bit prev;
      @(posedge clk); #5;
      prev = clk_pin;
      for (int i = 0; i < 40000; i++) begin
         @(posedge clk); #5;
         if (!prev && clk_pin) return;
         prev = clk_pin;
      end
   endtask

   task automatic period(output int t);
      int t0;
      wait_rise();
      wait_rise();
      t0 = tick_cnt;
      wait_rise();
      t = tick_cnt - t0;
   endtask

   initial begin
      int p;
      int held;
      repeat (3) @(negedge clk);
      // R1: reset state
      rd_addr = A_CTRL; #1; chk("R1 ctrl read", rd_data, 0);
      port_bit = 1'b1;  #1; chk("R1 pin=port_bit", clk_pin, 1);
      rst_n = 1'b1;
      @(negedge clk);
      rd_addr = A_LOAD; #1; chk("R1 count read", rd_data, 0);
      rd_addr = A_SEL;  #1; chk("R1 select read", rd_data, 0);
      port_bit = 1'b0;  #1; chk("R1 pin follows port", clk_pin, 0);
      cmp_on = 1'b1;

      // R2: source routing
      cur_req = "R2";
      for (int i = 0; i < 8; i++) begin @(negedge clk); port_bit = i[0]; end
      wr(A_SEL, 8'h01);
      @(negedge clk); #5; chk("R2 f1 low phase", clk_pin, 0);
      repeat (6) @(negedge clk);
      wr(A_SEL, 8'h02);
      repeat (12) @(negedge clk);
      wr(A_SEL, 8'hFF);
      rd_addr = A_SEL; #1; chk("R8 select bits only", rd_data, 3);

      // R7: low control bits ignored, counter stays stopped
      cur_req = "R7";
      ticks_on = 1'b1;
      wr(A_LOAD, 8'h07);
      wr(A_CTRL, 8'h7F);
      rd_addr = A_CTRL; #1; chk("R7 ctrl low bits read 0", rd_data, 0);
      cur_req = "R3";
      rd_addr = A_LOAD;
      repeat (100) @(negedge clk);
      chk("R3 count held while stopped", rd_data, 0);
      rd_addr = 4'h3; #1; chk("R8 unmapped reads 0", rd_data, 0);
      rd_addr = A_LOAD;

      // R4: run with n=7
      cur_req = "R4";
      wr(A_CTRL, 8'h80);
      rd_addr = A_CTRL; #1; chk("R7 run bit read", rd_data, 128);
      rd_addr = A_LOAD;
      period(p); chk("R4 period n=7 ticks", p, 16);

      // R6: reload write mid-count
      cur_req = "R6";
      @(negedge clk);
      while (!(rd_data == 4 && !f32_tick)) @(negedge clk);
      wr(A_LOAD, 8'h26);
      #1; chk("R6 count undisturbed", rd_data, 4);
      period(p); chk("R6 period n=0x26 ticks", p, 78);

      // R5: extreme values
      cur_req = "R5";
      wr(A_LOAD, 8'h00);
      period(p); chk("R5 period n=0 ticks", p, 2);
      wr(A_LOAD, 8'hFF);
      period(p); chk("R5 period n=0xFF ticks", p, 512);

      // R9: no tick, no change
      cur_req = "R9";
      ticks_on = 1'b0;
      repeat (40) @(negedge clk);
      held = rd_data;
      repeat (100) @(negedge clk);
      chk("R9 count held without tick", rd_data, held);

      // R3: stop mid-count, toggle holds
      cur_req = "R3";
      ticks_on = 1'b1;
      repeat (300) @(negedge clk);
      wr(A_CTRL, 8'h00);
      held = rd_data;
      p = clk_pin;
      repeat (2000) @(negedge clk);
      chk("R3 count held after stop", rd_data, held);
      chk("R3 toggle held after stop", clk_pin, p);
      wr(A_SEL, 8'h00);
      cur_req = "R2";
      repeat (10) @(negedge clk);

      cmp_on = 1'b0;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule